// File: doc/BRIEF.md
# Shared Multi-Channel Variable-Depth FIFO

This block is one storage pool shared by several DMA channels. Each channel sees its own logical FIFO, and that FIFO grows and shrinks with the channel's current usage. No channel has a fixed partition. The only bound is that all channels together hold no more entries than the pool depth. Whichever channel asks first is granted a free entry, so one busy channel may take every entry.

The pool has a push port and a pop port, and both can move a word in the same cycle. Each port carries a channel index, a data word and a valid/ready handshake. A pushed word goes into any free entry and is linked behind the last entry of its channel. A pop takes the oldest entry of the addressed channel, presents its word combinationally on the pop data output, and returns the entry to the free pool.

One entry is as wide as the data bus of the memory master that fills the pool. Entry width, total depth and channel count are parameters. The block drives a per-channel occupancy count, a per-channel empty flag and a global count of free entries.

Top module: `shared_chan_fifo`

## Requirements
- R1: While reset is asserted, and in the cycle reset ends, every channel occupancy is 0, every empty flag is 1 and the free count equals DEPTH.
- R2: push_ready_o is low exactly when the free count is 0 and no pop completes in the same cycle. This holds whatever channel is addressed. A stalled push changes no state.
- R3: pop_ready_o is low exactly when the channel on pop_chan_i holds no entries. A pop attempted while pop_ready_o is low changes no state.
- R4: Within one channel, words leave pop_data_o in exactly the order they were pushed, whatever pushes and pops other channels interleave. pop_data_o shows the oldest word of the channel on pop_chan_i while pop_ready_o is high.
- R5: The sum of all channel occupancies plus the free count always equals DEPTH.
- R6: A push and a pop in the same cycle both complete, on the same channel or on different ones. This also holds when the free count is 0, and in that case the free count stays 0.
- R7: No entry is reserved for any channel. A single channel can hold all DEPTH entries while the other channels are empty.
- R8: A completed push raises the occupancy of its channel by 1 and a completed pop lowers the occupancy of its channel by 1. Both complete on one channel leave its occupancy unchanged. The change is visible after the clock edge.
- R9: chan_empty_o bit c is 1 exactly when channel c's occupancy is 0. chan_occ_o holds channel c in bits [c*CW +: CW], where CW = $clog2(DEPTH+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset. Asserts asynchronously and is released on the clock |
| push_valid_i | input | 1 | Push request |
| push_chan_i | input | CHW | Channel that receives the pushed word |
| push_data_i | input | WIDTH | Pushed word |
| push_ready_o | output | 1 | The push completes this cycle if valid |
| pop_valid_i | input | 1 | Pop request |
| pop_chan_i | input | CHW | Channel to pop from |
| pop_ready_o | output | 1 | The addressed channel holds a word |
| pop_data_o | output | WIDTH | Oldest word of the addressed channel |
| chan_occ_o | output | CH_NUM*CW | Per-channel occupancy, packed |
| chan_empty_o | output | CH_NUM | Per-channel empty flags |
| free_cnt_o | output | CW | Number of free entries |

## Verification
The bench first fills the whole pool from one channel and then keeps pushing. A design that reserved a share per channel, or that miscounted the limit, would stall too early or accept a word with no entry to hold it. With the pool full, the bench pushes and pops in the same cycle, on the same channel and on different channels. A design without the bypass of the freed entry would stall the push or leak an entry. Pops from an empty channel, and a channel that goes from one word to empty while a push arrives for it, catch broken head and tail updates. Those bugs show up as reordered or stale words on pop_data_o. A long random interleave over all channels then compares every word and every counter with queue-based models on every clock.

// File: rtl/scf_pkg.sv
package scf_pkg;
  localparam int unsigned SCF_CH_NUM_DEF = 4;
  localparam int unsigned SCF_DEPTH_DEF  = 16;
  localparam int unsigned SCF_WIDTH_DEF  = 64;

  function automatic int unsigned scf_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/scf_rst_sync.sv
module scf_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/scf_free_pool.sv
module scf_free_pool #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4,
  parameter int unsigned CW    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          give_i,
  input  logic [AW-1:0] give_idx_i,
  output logic [AW-1:0] head_idx_o,
  output logic [CW-1:0] free_cnt_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] idx_q [DEPTH];
  logic [AW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (take_i) begin
      rd_d  = (rd_q == LAST) ? '0 : rd_q + 1'b1;
      cnt_d = cnt_d - 1'b1;
    end
    if (give_i) begin
      wr_d  = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      cnt_d = cnt_d + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= CW'(DEPTH);
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) idx_q[i] <= AW'(i);
    end else if (give_i) begin
      idx_q[wr_q] <= give_idx_i;
    end
  end

  assign head_idx_o = idx_q[rd_q];
  assign free_cnt_o = cnt_q;

  // R2: an entry is never taken from an empty free list
  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (cnt_q != '0));
  // R5: an entry is never returned to a full free list
  assert_no_double_free_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    give_i |-> (cnt_q != CW'(DEPTH)));
endmodule

// File: rtl/scf_chan_table.sv
module scf_chan_table #(
  parameter int unsigned CH_NUM = 4,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned AW     = 4,
  parameter int unsigned CW     = 5,
  parameter int unsigned CHW    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 push_fire_i,
  input  logic [CHW-1:0]       push_chan_i,
  input  logic [AW-1:0]        push_addr_i,
  input  logic                 pop_fire_i,
  input  logic [CHW-1:0]       pop_chan_i,
  output logic [AW-1:0]        pop_head_o,
  output logic [CH_NUM*CW-1:0] occ_o,
  output logic [CH_NUM-1:0]    empty_o
);
  logic [AW-1:0] head_q [CH_NUM];
  logic [AW-1:0] head_d [CH_NUM];
  logic [AW-1:0] tail_q [CH_NUM];
  logic [AW-1:0] tail_d [CH_NUM];
  logic [CW-1:0] cnt_q  [CH_NUM];
  logic [CW-1:0] cnt_d  [CH_NUM];
  logic [AW-1:0] link_q [DEPTH];
  logic          link_we;
  logic [AW-1:0] link_wa;

  always_comb begin
    for (int c = 0; c < CH_NUM; c++) begin
      head_d[c] = head_q[c];
      tail_d[c] = tail_q[c];
      cnt_d[c]  = cnt_q[c];
    end
    link_we = 1'b0;
    link_wa = tail_q[push_chan_i];
    if (pop_fire_i) begin
      if (push_fire_i && (push_chan_i == pop_chan_i) && (cnt_q[pop_chan_i] == CW'(1)))
        head_d[pop_chan_i] = push_addr_i;
      else
        head_d[pop_chan_i] = link_q[head_q[pop_chan_i]];
      cnt_d[pop_chan_i] = cnt_d[pop_chan_i] - 1'b1;
    end
    if (push_fire_i) begin
      if (cnt_q[push_chan_i] == '0) head_d[push_chan_i] = push_addr_i;
      else                          link_we = 1'b1;
      tail_d[push_chan_i] = push_addr_i;
      cnt_d[push_chan_i]  = cnt_d[push_chan_i] + 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < CH_NUM; g++) begin : g_chan
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          head_q[g] <= '0;
          tail_q[g] <= '0;
          cnt_q[g]  <= '0;
        end else begin
          head_q[g] <= head_d[g];
          tail_q[g] <= tail_d[g];
          cnt_q[g]  <= cnt_d[g];
        end
      end
      assign occ_o[g*CW +: CW] = cnt_q[g];
      assign empty_o[g]        = (cnt_q[g] == '0);
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (link_we) link_q[link_wa] <= push_addr_i;
  end

  assign pop_head_o = head_q[pop_chan_i];

  // R3: a pop never reaches a channel that holds nothing
  assert_pop_nonempty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_fire_i |-> (cnt_q[pop_chan_i] != '0));
  // R9: popping the last word with no push to that channel empties it
  assert_last_pop_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_fire_i && (cnt_q[pop_chan_i] == CW'(1)) &&
     !(push_fire_i && (push_chan_i == pop_chan_i))) |=> empty_o[$past(pop_chan_i)]);
endmodule

// File: rtl/scf_store.sv
module scf_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 64,
  parameter int unsigned AW    = 4
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/shared_chan_fifo.sv
module shared_chan_fifo
  import scf_pkg::*;
#(
  parameter int unsigned CH_NUM = SCF_CH_NUM_DEF,
  parameter int unsigned DEPTH  = SCF_DEPTH_DEF,
  parameter int unsigned WIDTH  = SCF_WIDTH_DEF,
  localparam int unsigned AW    = scf_bits(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1),
  localparam int unsigned CHW   = scf_bits(CH_NUM)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 push_valid_i,
  input  logic [CHW-1:0]       push_chan_i,
  input  logic [WIDTH-1:0]     push_data_i,
  output logic                 push_ready_o,
  input  logic                 pop_valid_i,
  input  logic [CHW-1:0]       pop_chan_i,
  output logic                 pop_ready_o,
  output logic [WIDTH-1:0]     pop_data_o,
  output logic [CH_NUM*CW-1:0] chan_occ_o,
  output logic [CH_NUM-1:0]    chan_empty_o,
  output logic [CW-1:0]        free_cnt_o
);
  logic          rst_n;
  logic          push_fire, pop_fire, both_fire;
  logic [AW-1:0] free_head, pop_head, alloc_addr;

  scf_rst_sync u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n));

  assign pop_ready_o  = ~chan_empty_o[pop_chan_i];
  assign pop_fire     = pop_valid_i & pop_ready_o;
  assign push_ready_o = (free_cnt_o != '0) | pop_fire;
  assign push_fire    = push_valid_i & push_ready_o;
  assign both_fire    = push_fire & pop_fire;
  // with both ports moving, the freed entry is reused at once
  assign alloc_addr   = both_fire ? pop_head : free_head;

  scf_free_pool #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_free (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .take_i     (push_fire & ~pop_fire),
    .give_i     (pop_fire & ~push_fire),
    .give_idx_i (pop_head),
    .head_idx_o (free_head),
    .free_cnt_o (free_cnt_o)
  );

  scf_chan_table #(.CH_NUM(CH_NUM), .DEPTH(DEPTH), .AW(AW), .CW(CW), .CHW(CHW)) u_tab (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .push_fire_i (push_fire),
    .push_chan_i (push_chan_i),
    .push_addr_i (alloc_addr),
    .pop_fire_i  (pop_fire),
    .pop_chan_i  (pop_chan_i),
    .pop_head_o  (pop_head),
    .occ_o       (chan_occ_o),
    .empty_o     (chan_empty_o)
  );

  scf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (push_fire),
    .waddr_i (alloc_addr),
    .wdata_i (push_data_i),
    .raddr_i (pop_head),
    .rdata_o (pop_data_o)
  );

  logic [CW+CHW:0] occ_sum;
  always_comb begin
    occ_sum = '0;
    for (int c = 0; c < CH_NUM; c++) occ_sum = occ_sum + chan_occ_o[c*CW +: CW];
  end

  // R5: occupancies and free entries always add up to the pool depth
  assert_pool_conserved_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (occ_sum + free_cnt_o) == DEPTH);
  // R6: a push and a pop in one cycle leave the free count unchanged
  assert_both_keep_free_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (push_valid_i && pop_valid_i && pop_ready_o) |=> (free_cnt_o == $past(free_cnt_o)));
  // R2: a lone push into a full pool is refused
  assert_full_stall_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (free_cnt_o == '0 && !pop_valid_i) |-> !push_ready_o);
  // R8: a lone push takes exactly one free entry
  assert_push_takes_one_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (push_valid_i && push_ready_o && !pop_valid_i) |=> (free_cnt_o == $past(free_cnt_o) - 1'b1));
endmodule

// File: tb/shared_chan_fifo_tb_top.sv
`timescale 1ns/1ps
module shared_chan_fifo_tb_top;
  localparam int CH    = 4;
  localparam int DEPTH = 16;
  localparam int WIDTH = 64;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int CHW   = 2;

  logic                 clk_i = 1'b0;
  logic                 rst_ni;
  logic                 push_valid_i, pop_valid_i;
  logic [CHW-1:0]       push_chan_i, pop_chan_i;
  logic [WIDTH-1:0]     push_data_i, pop_data_o;
  logic                 push_ready_o, pop_ready_o;
  logic [CH*CW-1:0]     chan_occ_o;
  logic [CH-1:0]        chan_empty_o;
  logic [CW-1:0]        free_cnt_o;

  always #2.5 clk_i = ~clk_i;

  shared_chan_fifo #(.CH_NUM(CH), .DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (.*);

  int tests = 0, fails = 0;
  logic [WIDTH-1:0] mq [CH][$];
  int seq = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int total();
    int t = 0;
    for (int c = 0; c < CH; c++) t += mq[c].size();
    return t;
  endfunction

  task automatic check_state();
    for (int c = 0; c < CH; c++) begin
      chk(chan_occ_o[c*CW +: CW] == mq[c].size(), "R8", "occupancy",
          chan_occ_o[c*CW +: CW], mq[c].size());
      chk(chan_empty_o[c] == (mq[c].size() == 0), "R9", "empty flag",
          chan_empty_o[c], mq[c].size() == 0);
    end
    chk(free_cnt_o == DEPTH - total(), "R5", "free count", free_cnt_o, DEPTH - total());
  endtask

  task automatic step(input bit pv, input int pc, input bit qv, input int qc);
    bit exp_pop_rdy, exp_push_rdy, pf, qf;
    logic [WIDTH-1:0] d;
    @(negedge clk_i);
    check_state();
    seq++;
    d = {8'(pc), 24'h0, 32'(seq)};
    push_valid_i = pv; push_chan_i = CHW'(pc); push_data_i = d;
    pop_valid_i = qv;  pop_chan_i = CHW'(qc);
    #1;
    exp_pop_rdy  = mq[qc].size() != 0;
    qf           = qv && exp_pop_rdy;
    exp_push_rdy = (total() < DEPTH) || qf;
    pf           = pv && exp_push_rdy;
    chk(pop_ready_o == exp_pop_rdy, "R3", "pop ready", pop_ready_o, exp_pop_rdy);
    chk(push_ready_o == exp_push_rdy, (total() == DEPTH && qf) ? "R6" : "R2",
        "push ready", push_ready_o, exp_push_rdy);
    if (exp_pop_rdy)
      chk(pop_data_o == mq[qc][0], "R4", "pop data", pop_data_o, mq[qc][0]);
    if (qf) void'(mq[qc].pop_front());
    if (pf) mq[pc].push_back(d);
  endtask

  initial begin
    #1000000;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails + 1);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    push_valid_i = 0; pop_valid_i = 0; push_chan_i = 0; pop_chan_i = 0; push_data_i = 0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    for (int c = 0; c < CH; c++) begin
      chk(chan_occ_o[c*CW +: CW] == 0, "R1", "reset occupancy", chan_occ_o[c*CW +: CW], 0);
      chk(chan_empty_o[c] == 1'b1, "R1", "reset empty", chan_empty_o[c], 1);
    end
    chk(free_cnt_o == DEPTH, "R1", "reset free count", free_cnt_o, DEPTH);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(free_cnt_o == DEPTH, "R1", "free count after release", free_cnt_o, DEPTH);
    repeat (3) step(0, 0, 0, 0);

    // R7: one channel takes the whole pool; extra pushes stall (R2)
    repeat (DEPTH + 3) step(1, 0, 0, 0);
    @(negedge clk_i);
    chk(chan_occ_o[0 +: CW] == DEPTH, "R7", "single channel holds all",
        chan_occ_o[0 +: CW], DEPTH);
    step(1, 2, 1, 3);  // R2, R3: blocked push and pop of an empty channel

    // R6: full pool, push and pop together
    repeat (4) step(1, 1, 1, 0);
    repeat (4) step(1, 0, 1, 0);
    repeat (3) step(1, 1, 1, 1);

    // drain everything (R4 order)
    for (int c = 0; c < CH; c++) repeat (DEPTH + 1) step(0, 0, 1, c);

    // last word of a channel popped while a push arrives for it (R4, R8)
    step(1, 2, 0, 0);
    repeat (5) step(1, 2, 1, 2);
    repeat (2) step(0, 0, 1, 2);

    // random interleave over all channels
    for (int i = 0; i < 4000; i++) begin
      int bias = (i / 500) % 2;
      step(($urandom % 4) < (bias ? 3 : 2), $urandom % CH,
           ($urandom % 4) < (bias ? 2 : 3), $urandom % CH);
    end
    @(negedge clk_i);
    check_state();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule